// File: doc/BRIEF.md
# Instruction Address Match Patch Unit

This block sits on a CPU's instruction fetch path. It holds six programmable 24-bit detect addresses, and each one has its own enable bit. The block compares every opcode fetch with the enabled entries. When one of them matches, the block replaces the opcode byte going to the CPU with the software-interrupt opcode 8'h01, so the CPU traps to a handler. Operand bytes and data reads at a matching address pass through unchanged.

Software writes the detect addresses a byte at a time through a small address-decoded write port. The intended sequence has three steps: clear the entry's enable bit, write its three address bytes, then set the enable bit again. The substitution path is purely combinational, so the fetch takes no extra cycle. A match flag and the index of the lowest-numbered matching entry are presented in the same cycle as the substituted byte.

Top module: `addr_patch_unit`

## Requirements
- R1: After reset all enable bits and all address bytes are 0. No fetch is altered and `hit_o` stays 0, including a fetch from address 0.
- R2: When `fetch_first_i` is 1 and an enabled entry equals `fetch_addr_i`, `fetch_data_o` is 8'h01 and `hit_o` is 1.
- R3: When `fetch_first_i` is 0, `fetch_data_o` equals `fetch_data_i` and `hit_o` is 0, whatever the address.
- R4: An opcode fetch whose address matches no enabled entry passes `fetch_data_i` through unchanged, with `hit_o` 0.
- R5: An entry whose enable bit is 0 never matches, and it keeps its stored address for a later re-enable.
- R6: When several enabled entries match, there is a single substitution, and `hit_idx_o` gives the lowest-numbered matching entry.
- R7: A write takes effect at the clock edge where `wr_en_i` is 1. `wr_sel_i` = 3*e+b selects byte b of entry e, where b=0 is bits 7:0, b=1 is bits 15:8 and b=2 is bits 23:16. `wr_sel_i` = 18 loads the enable bits from `wr_data_i[5:0]`, with bit e enabling entry e. Values 19 to 31, and any cycle with `wr_en_i` at 0, change nothing.
- R8: The substitution is combinational: `fetch_data_o`, `hit_o` and `hit_idx_o` follow the fetch inputs in the same cycle, with no clock edge in between.
- R9: Writing one address byte leaves the other bytes of that entry, and all enable bits, unchanged.
- R10: When `hit_o` is 0, `hit_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 5 | Register select (see R7) |
| wr_data_i | input | 8 | Register write byte |
| fetch_addr_i | input | 24 | Fetch address |
| fetch_data_i | input | 8 | Fetched byte from memory |
| fetch_first_i | input | 1 | High on the first (opcode) byte of an instruction |
| fetch_data_o | output | 8 | Byte delivered to the CPU |
| hit_o | output | 1 | Opcode replaced this cycle |
| hit_idx_o | output | 3 | Lowest matching entry index |

## Verification
Assertions check the output relations on every cycle:
- pass-through when there is no opcode strobe;
- the trap byte whenever the flag is set;
- a zero index without a hit;
- the reported index is a matching entry and no lower-numbered entry matches;
- the enable register loads on a write to its select and stays stable when an address byte is written.

Only the bench scenarios can show the rest, because the stored addresses are visible only through later fetches:
- the byte placement of each select value;
- that selects above 18 are ignored;
- retention of an address across disable and re-enable;
- the worked example around 24'hFF001F.

// File: rtl/ap_pkg.sv
package ap_pkg;
  localparam int BYTE_W          = 8;
  localparam int DEF_NUM_ENT     = 6;
  localparam int DEF_ADDR_W      = 24;
  localparam logic [7:0] DEF_TRAP_OP = 8'h01;
endpackage

// File: rtl/ap_regfile.sv
module ap_regfile #(
  parameter int NUM_ENT = ap_pkg::DEF_NUM_ENT,
  parameter int ADDR_W  = ap_pkg::DEF_ADDR_W,
  parameter int SEL_W   = 5
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [SEL_W-1:0]               wr_sel_i,
  input  logic [ap_pkg::BYTE_W-1:0]      wr_data_i,
  output logic [NUM_ENT-1:0][ADDR_W-1:0] addr_o,
  output logic [NUM_ENT-1:0]             en_o
);
  localparam int BYTES  = ADDR_W / ap_pkg::BYTE_W;
  localparam int EN_SEL = NUM_ENT * BYTES;

  logic [NUM_ENT-1:0][ADDR_W-1:0] addr_q;
  logic [NUM_ENT-1:0]             en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (wr_en_i) begin
      for (int e = 0; e < NUM_ENT; e++) begin
        for (int b = 0; b < BYTES; b++) begin
          if (wr_sel_i == SEL_W'(e * BYTES + b))
            addr_q[e][b*ap_pkg::BYTE_W +: ap_pkg::BYTE_W] <= wr_data_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     en_q <= '0;
    else if (wr_en_i && wr_sel_i == SEL_W'(EN_SEL))  en_q <= wr_data_i[NUM_ENT-1:0];
  end

  assign addr_o = addr_q;
  assign en_o   = en_q;

  // R7
  en_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_W'(EN_SEL)) |=> en_o == $past(wr_data_i[NUM_ENT-1:0]));

  // R9
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i || wr_sel_i != SEL_W'(EN_SEL)) |=> $stable(en_o));
endmodule

// File: rtl/ap_match.sv
module ap_match #(
  parameter int NUM_ENT = ap_pkg::DEF_NUM_ENT,
  parameter int ADDR_W  = ap_pkg::DEF_ADDR_W
) (
  input  logic [NUM_ENT-1:0][ADDR_W-1:0] addr_i,
  input  logic [NUM_ENT-1:0]             en_i,
  input  logic [ADDR_W-1:0]              fetch_addr_i,
  input  logic                           fetch_first_i,
  output logic [NUM_ENT-1:0]             match_o
);
  for (genvar e = 0; e < NUM_ENT; e++) begin : g_cmp
    assign match_o[e] = fetch_first_i & en_i[e] & (addr_i[e] == fetch_addr_i);
  end
endmodule

// File: rtl/ap_prio.sv
module ap_prio #(
  parameter int NUM_ENT = ap_pkg::DEF_NUM_ENT,
  parameter int IDX_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_ENT-1:0] match_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);
  // lowest index wins: scan downwards so the last assignment is the lowest
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  // R6
  idx_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> match_i[idx_o]);

  // R6
  idx_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((match_i & ((NUM_ENT'(1) << idx_o) - NUM_ENT'(1))) == '0));
endmodule

// File: rtl/addr_patch_unit.sv
module addr_patch_unit #(
  parameter int         NUM_ENT = ap_pkg::DEF_NUM_ENT,
  parameter int         ADDR_W  = ap_pkg::DEF_ADDR_W,
  parameter logic [7:0] TRAP_OP = ap_pkg::DEF_TRAP_OP,
  localparam int        SEL_W   = $clog2(NUM_ENT * (ADDR_W / 8) + 1),
  localparam int        IDX_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic [7:0]        fetch_data_i,
  input  logic              fetch_first_i,
  output logic [7:0]        fetch_data_o,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o
);
  logic [NUM_ENT-1:0][ADDR_W-1:0] addr_q;
  logic [NUM_ENT-1:0]             en_q;
  logic [NUM_ENT-1:0]             match;

  ap_regfile #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) i_regfile (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .addr_o   (addr_q),
    .en_o     (en_q)
  );

  ap_match #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W)) i_match (
    .addr_i       (addr_q),
    .en_i         (en_q),
    .fetch_addr_i (fetch_addr_i),
    .fetch_first_i(fetch_first_i),
    .match_o      (match)
  );

  ap_prio #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) i_prio (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .match_i(match),
    .hit_o  (hit_o),
    .idx_o  (hit_idx_o)
  );

  assign fetch_data_o = hit_o ? TRAP_OP : fetch_data_i;

  // R3
  no_strobe_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_first_i |-> (fetch_data_o == fetch_data_i && !hit_o));

  // R2
  hit_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> fetch_data_o == TRAP_OP);

  // R10
  idle_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (hit_idx_o == '0 && fetch_data_o == fetch_data_i));
endmodule

// File: tb/test_addr_patch_unit.sv
`timescale 1ns/1ps
module test_addr_patch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic [23:0] f_addr = '0;
  logic [7:0]  f_data = '0;
  logic        f_first = 1'b0;
  logic [7:0]  f_out;
  logic        hit;
  logic [2:0]  hit_idx;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  addr_patch_unit i_addr_patch_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .fetch_addr_i(f_addr), .fetch_data_i(f_data), .fetch_first_i(f_first),
    .fetch_data_o(f_out), .hit_o(hit), .hit_idx_o(hit_idx)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] s, logic [7:0] d, logic en = 1'b1);
    @(negedge clk);
    wr_en = en; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_addr(int e, logic [23:0] a);
    for (int b = 0; b < 3; b++) wr(5'(e * 3 + b), a[b*8 +: 8]);
  endtask

  // combinational sample: no clock edge between drive and check (R8)
  task automatic fetch(string tag, logic [23:0] a, logic [7:0] d, logic first,
                       logic [7:0] exp_d, logic exp_hit, logic [2:0] exp_idx);
    @(negedge clk);
    f_addr = a; f_data = d; f_first = first;
    #1;
    chk({tag, " data"}, f_out, exp_d);
    chk({tag, " hit"}, hit, exp_hit);
    chk({tag, " idx"}, hit_idx, exp_idx);
  endtask

  task automatic t_reset;
    fetch("R1 reset addr0", 24'h0, 8'h4A, 1'b1, 8'h4A, 1'b0, 3'd0);
    fetch("R10 no hit idx", 24'hFF001F, 8'h33, 1'b1, 8'h33, 1'b0, 3'd0);
  endtask

  task automatic t_example;
    wr(5'd18, 8'h00);
    set_addr(0, 24'hFF001F);
    wr(5'd18, 8'h01);
    fetch("R4 before", 24'hFF001C, 8'hA8, 1'b1, 8'hA8, 1'b0, 3'd0);
    fetch("R2 match",  24'hFF001F, 8'h4A, 1'b1, 8'h01, 1'b1, 3'd0);
    fetch("R3 operand", 24'hFF0020, 8'h00, 1'b0, 8'h00, 1'b0, 3'd0);
    fetch("R3 same addr no strobe", 24'hFF001F, 8'h4A, 1'b0, 8'h4A, 1'b0, 3'd0);
    fetch("R4 after", 24'hFF0022, 8'h4A, 1'b1, 8'h4A, 1'b0, 3'd0);
    // R8: flip the strobe without a clock edge
    f_first = 1'b1; f_addr = 24'hFF001F; f_data = 8'h4A;
    #1 chk("R8 same cycle", f_out, 8'h01);
    f_first = 1'b0;
    #1 chk("R8 same cycle drop", f_out, 8'h4A);
  endtask

  task automatic t_disable;
    wr(5'd18, 8'h00);
    fetch("R5 disabled", 24'hFF001F, 8'h4A, 1'b1, 8'h4A, 1'b0, 3'd0);
    wr(5'd18, 8'h01);
    fetch("R5 retained", 24'hFF001F, 8'h4A, 1'b1, 8'h01, 1'b1, 3'd0);
  endtask

  task automatic t_each_entry;
    for (int e = 0; e < 6; e++) set_addr(e, 24'h100000 + 24'(e * 16));
    wr(5'd18, 8'h3F);
    for (int e = 0; e < 6; e++)
      fetch("R7 entry map", 24'h100000 + 24'(e * 16), 8'h55, 1'b1, 8'h01, 1'b1, 3'(e));
    wr(5'd18, 8'h3F & ~8'h08);
    fetch("R5 one bit off", 24'h100030, 8'h55, 1'b1, 8'h55, 1'b0, 3'd0);
    fetch("R5 neighbour on", 24'h100040, 8'h55, 1'b1, 8'h01, 1'b1, 3'd4);
  endtask

  task automatic t_multi;
    set_addr(2, 24'h123456);
    set_addr(4, 24'h123456);
    set_addr(5, 24'h123456);
    wr(5'd18, 8'h34);
    fetch("R6 lowest of 2,4,5", 24'h123456, 8'h77, 1'b1, 8'h01, 1'b1, 3'd2);
    wr(5'd18, 8'h30);
    fetch("R6 lowest of 4,5", 24'h123456, 8'h77, 1'b1, 8'h01, 1'b1, 3'd4);
  endtask

  task automatic t_bytes;
    wr(5'd18, 8'h00);
    set_addr(3, 24'hABCDEF);
    wr(5'd18, 8'h08);
    fetch("R7 full addr", 24'hABCDEF, 8'h90, 1'b1, 8'h01, 1'b1, 3'd3);
    wr(5'd10, 8'h11);  // entry 3, bits 15:8
    fetch("R9 old addr gone", 24'hABCDEF, 8'h90, 1'b1, 8'h90, 1'b0, 3'd0);
    fetch("R9 mid byte only", 24'hAB11EF, 8'h90, 1'b1, 8'h01, 1'b1, 3'd3);
    wr(5'd11, 8'h22);  // entry 3, bits 23:16
    fetch("R7 high byte", 24'h2211EF, 8'h90, 1'b1, 8'h01, 1'b1, 3'd3);
    wr(5'd9, 8'h33);   // entry 3, bits 7:0
    fetch("R7 low byte", 24'h221133, 8'h90, 1'b1, 8'h01, 1'b1, 3'd3);
  endtask

  task automatic t_ignored;
    wr(5'd19, 8'h00);
    wr(5'd31, 8'h00);
    fetch("R7 sel19/31 ignored", 24'h221133, 8'h90, 1'b1, 8'h01, 1'b1, 3'd3);
    wr(5'd9, 8'hEE, 1'b0);
    wr(5'd18, 8'h00, 1'b0);
    fetch("R7 wr_en low ignored", 24'h221133, 8'h90, 1'b1, 8'h01, 1'b1, 3'd3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_example();
    t_disable();
    t_each_entry();
    t_multi();
    t_bytes();
    t_ignored();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule